// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is an unpipelined 32-bit processor. On every clock it fetches one instruction word, decodes it, reads up to two registers, runs the ALU, and at the next rising edge commits the register write, the optional data-memory write and the new program counter. The instruction memory and the data memory each have a combinational read port. The data memory also has a clocked write port with a write enable. Both sides see the same word-addressed space, so the constant-load instruction can fetch a literal placed in the instruction stream.

The program counter counts words, so sequential flow adds 1. Two instruction formats share the top fields: opcode in bits 31:26, destination Rc in 25:21, first source Ra in 20:16. The register format then holds Rb in 15:11. The constant format holds a 16-bit two's-complement constant in 15:0. Register 31 always reads as zero. The register file is a separate submodule with two read ports and one write port. Its second read address comes from Rc instead of Rb when a store needs its data register.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC (`imem_addr`) to 0 at the next edge. While `rst` is high, neither a register write nor `dmem_we` takes place.
- R2: Every instruction that is not a taken branch or a jump advances the PC by exactly 1.
- R3: Register-form ALU operations compute Rc = Ra op Rb with opcodes 0x18 ADD, 0x19 SUB, 0x20 AND, 0x21 OR, 0x22 XOR. Fields are opcode 31:26, Rc 25:21, Ra 20:16, Rb 15:11.
- R4: Each constant form uses the register-form opcode plus 0x10. The second operand is bits 15:0 sign-extended to 32 bits.
- R5: Comparisons 0x1C EQ, 0x1D signed LT and 0x1E signed LE (and their constant forms) write 1 when true and 0 when false.
- R6: Shifts 0x24 SHL, 0x25 SHR (zero fill) and 0x26 SAR (sign fill) use only the low 5 bits of the second operand.
- R7: Register 31 reads as zero, and writes to it are discarded.
- R8: LD (0x38) writes the word at address Ra + sext(C) into Rc.
- R9: ST (0x39) writes register Rc to address Ra + sext(C). `dmem_we` is high only for ST.
- R10: LDR (0x3F) writes the word at address PC + 1 + sext(C) into Rc, whatever Ra holds.
- R11: BRZ (0x3D) and BRNZ (0x3E) write PC + 1 into Rc. The PC then becomes PC + 1 + sext(C) when Ra is zero (BRZ) or nonzero (BRNZ), and PC + 1 otherwise.
- R12: JMP (0x3B) writes PC + 1 into Rc and loads the PC from register Ra.
- R13: Any other opcode raises `illegal`, writes neither a register nor memory, and advances the PC by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Word address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Word address for data read or write |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, combinational |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, sampled at the rising edge |
| illegal | output | 1 | Current instruction has an undefined opcode |

## Verification
The properties assume that `imem_data` and `dmem_rdata` are stable, known functions of the addresses presented in the same cycle. They also assume that any register a jump or branch reads has been written since power-up. The stimulus keeps within this: one shared memory array is fully initialised before reset is released, and the program writes each register before it reads it. The program ends in a self-branch on register 31, so the fetch address never leaves the initialised region. A second reset in mid-run re-executes the program from address 0 over the state left behind.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam logic [5:0] OP_ADD   = 6'h18;
   localparam logic [5:0] OP_SUB   = 6'h19;
   localparam logic [5:0] OP_CEQ   = 6'h1C;
   localparam logic [5:0] OP_CLT   = 6'h1D;
   localparam logic [5:0] OP_CLE   = 6'h1E;
   localparam logic [5:0] OP_AND   = 6'h20;
   localparam logic [5:0] OP_OR    = 6'h21;
   localparam logic [5:0] OP_XOR   = 6'h22;
   localparam logic [5:0] OP_SHL   = 6'h24;
   localparam logic [5:0] OP_SHR   = 6'h25;
   localparam logic [5:0] OP_SAR   = 6'h26;
   localparam logic [5:0] CONST_OFS = 6'h10;
   localparam logic [5:0] OP_LD    = 6'h38;
   localparam logic [5:0] OP_ST    = 6'h39;
   localparam logic [5:0] OP_JMP   = 6'h3B;
   localparam logic [5:0] OP_BRZ   = 6'h3D;
   localparam logic [5:0] OP_BRNZ  = 6'h3E;
   localparam logic [5:0] OP_LDR   = 6'h3F;

   typedef enum logic [3:0] {
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR,
      FN_SHL, FN_SHR, FN_SAR, FN_EQ, FN_LT, FN_LE
   } alu_fn_e;

   typedef enum logic [1:0] {
      WB_LINK, WB_ALU, WB_MEM
   } wb_sel_e;

   typedef struct packed {
      alu_fn_e fn;
      logic    use_const;
      wb_sel_e wb;
      logic    rf_we;
      logic    mem_we;
      logic    src2_is_dst;
      logic    addr_pc_rel;
      logic    br_if_zero;
      logic    br_if_nonzero;
      logic    is_jmp;
      logic    bad;
   } ctrl_t;

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32
) (
   input  logic                     clk,
   input  logic [$clog2(NREG)-1:0]  ra1,
   input  logic [$clog2(NREG)-1:0]  ra2,
   output logic [XLEN-1:0]          rd1,
   output logic [XLEN-1:0]          rd2,
   input  logic                     we,
   input  logic [$clog2(NREG)-1:0]  wa,
   input  logic [XLEN-1:0]          wd
);
   localparam int AW = $clog2(NREG);
   localparam logic [AW-1:0] ZREG = AW'(NREG - 1);

   if ((1 << AW) != NREG) begin : g_bad_nreg
      $error("sc_regfile: NREG must be a power of two");
   end

   logic [XLEN-1:0] q [NREG];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREG - 1; i++) begin
         if (we && wa == AW'(i)) q[i] <= wd;
      end
   end

   assign rd1 = (ra1 == ZREG) ? '0 : q[ra1];
   assign rd2 = (ra2 == ZREG) ? '0 : q[ra2];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int SHIFT_STYLE = 1
) (
   input  alu_fn_e          fn,
   input  logic [XLEN-1:0]  a,
   input  logic [XLEN-1:0]  b,
   output logic [XLEN-1:0]  y
);
   localparam int SH_W = $clog2(XLEN);

   if ((1 << SH_W) != XLEN) begin : g_bad_xlen
      $error("sc_alu: XLEN must be a power of two");
   end
   if (SHIFT_STYLE != 0 && SHIFT_STYLE != 1) begin : g_bad_style
      $error("sc_alu: SHIFT_STYLE must be 0 or 1");
   end

   logic [SH_W-1:0] amt;
   logic [XLEN-1:0] sh_y;
   assign amt = b[SH_W-1:0];

   if (SHIFT_STYLE == 0) begin : g_shift_op
      always_comb begin
         case (fn)
            FN_SHL:  sh_y = a << amt;
            FN_SAR:  sh_y = $unsigned($signed(a) >>> amt);
            default: sh_y = a >> amt;
         endcase
      end
   end else begin : g_shift_barrel
      logic            fill;
      logic [XLEN-1:0] src;
      logic [XLEN-1:0] stg [SH_W+1];
      logic [XLEN-1:0] flip;

      assign fill = (fn == FN_SAR) ? a[XLEN-1] : 1'b0;

      always_comb begin
         for (int i = 0; i < XLEN; i++) src[i] = (fn == FN_SHL) ? a[XLEN-1-i] : a[i];
      end
      assign stg[0] = src;

      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         assign stg[k+1] = amt[k] ? {{(1 << k){fill}}, stg[k][XLEN-1:(1 << k)]} : stg[k];
      end

      always_comb begin
         for (int i = 0; i < XLEN; i++) flip[i] = stg[SH_W][XLEN-1-i];
      end
      assign sh_y = (fn == FN_SHL) ? flip : stg[SH_W];
   end

   logic lt_s;
   assign lt_s = $signed(a) < $signed(b);

   always_comb begin
      case (fn)
         FN_ADD:  y = a + b;
         FN_SUB:  y = a - b;
         FN_AND:  y = a & b;
         FN_OR:   y = a | b;
         FN_XOR:  y = a ^ b;
         FN_EQ:   y = XLEN'(a == b);
         FN_LT:   y = XLEN'(lt_s);
         FN_LE:   y = XLEN'(lt_s | (a == b));
         default: y = sh_y;
      endcase
   end

endmodule

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic [5:0] op,
   output ctrl_t      c
);
   logic [5:0] base;
   logic       is_c;

   always_comb begin
      is_c = (op >= (OP_ADD + CONST_OFS)) && (op <= (OP_SAR + CONST_OFS));
      base = is_c ? (op - CONST_OFS) : op;

      c               = '0;
      c.fn            = FN_ADD;
      c.wb            = WB_ALU;
      c.bad           = 1'b1;

      case (base)
         OP_ADD: begin c.fn = FN_ADD; c.bad = 1'b0; end
         OP_SUB: begin c.fn = FN_SUB; c.bad = 1'b0; end
         OP_CEQ: begin c.fn = FN_EQ;  c.bad = 1'b0; end
         OP_CLT: begin c.fn = FN_LT;  c.bad = 1'b0; end
         OP_CLE: begin c.fn = FN_LE;  c.bad = 1'b0; end
         OP_AND: begin c.fn = FN_AND; c.bad = 1'b0; end
         OP_OR:  begin c.fn = FN_OR;  c.bad = 1'b0; end
         OP_XOR: begin c.fn = FN_XOR; c.bad = 1'b0; end
         OP_SHL: begin c.fn = FN_SHL; c.bad = 1'b0; end
         OP_SHR: begin c.fn = FN_SHR; c.bad = 1'b0; end
         OP_SAR: begin c.fn = FN_SAR; c.bad = 1'b0; end
         default: ;
      endcase

      if (!c.bad) begin
         c.use_const = is_c;
         c.rf_we     = 1'b1;
      end else begin
         case (op)
            OP_LD: begin
               c.bad = 1'b0; c.use_const = 1'b1; c.rf_we = 1'b1; c.wb = WB_MEM;
            end
            OP_ST: begin
               c.bad = 1'b0; c.use_const = 1'b1; c.mem_we = 1'b1; c.src2_is_dst = 1'b1;
            end
            OP_LDR: begin
               c.bad = 1'b0; c.rf_we = 1'b1; c.wb = WB_MEM; c.addr_pc_rel = 1'b1;
            end
            OP_JMP: begin
               c.bad = 1'b0; c.rf_we = 1'b1; c.wb = WB_LINK; c.is_jmp = 1'b1;
            end
            OP_BRZ: begin
               c.bad = 1'b0; c.rf_we = 1'b1; c.wb = WB_LINK; c.br_if_zero = 1'b1;
            end
            OP_BRNZ: begin
               c.bad = 1'b0; c.rf_we = 1'b1; c.wb = WB_LINK; c.br_if_nonzero = 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter logic [XLEN-1:0] RESET_PC    = '0,
   parameter int              SHIFT_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [XLEN-1:0]  imem_addr,
   input  logic [31:0]      imem_data,
   output logic [XLEN-1:0]  dmem_addr,
   input  logic [XLEN-1:0]  dmem_rdata,
   output logic [XLEN-1:0]  dmem_wdata,
   output logic             dmem_we,
   output logic             illegal
);
   localparam int NREG  = 32;
   localparam int IMM_W = 16;

   if (XLEN < IMM_W) begin : g_bad_width
      $error("sc_core: XLEN must be at least the constant width");
   end

   logic [XLEN-1:0] pc, pc_inc, pc_nxt, br_tgt;
   logic [5:0]      op;
   logic [4:0]      f_rc, f_ra, f_rb, ra2;
   logic [XLEN-1:0] imm, rd1, rd2, opb, alu_y, rf_wd;
   logic            rf_we, taken;
   ctrl_t           ctl;

   assign op   = imem_data[31:26];
   assign f_rc = imem_data[25:21];
   assign f_ra = imem_data[20:16];
   assign f_rb = imem_data[15:11];
   assign imm  = {{(XLEN-IMM_W){imem_data[IMM_W-1]}}, imem_data[IMM_W-1:0]};

   sc_decode u_dec (
      .op (op),
      .c  (ctl)
   );

   assign ra2 = ctl.src2_is_dst ? f_rc : f_rb;

   sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk (clk),
      .ra1 (f_ra),
      .ra2 (ra2),
      .rd1 (rd1),
      .rd2 (rd2),
      .we  (rf_we),
      .wa  (f_rc),
      .wd  (rf_wd)
   );

   assign opb = ctl.use_const ? imm : rd2;

   sc_alu #(.XLEN(XLEN), .SHIFT_STYLE(SHIFT_STYLE)) u_alu (
      .fn (ctl.fn),
      .a  (rd1),
      .b  (opb),
      .y  (alu_y)
   );

   assign pc_inc = pc + XLEN'(1);
   assign br_tgt = pc_inc + imm;

   assign dmem_addr  = ctl.addr_pc_rel ? br_tgt : alu_y;
   assign dmem_wdata = rd2;
   assign dmem_we    = ctl.mem_we & ~rst;
   assign rf_we      = ctl.rf_we & ~rst;
   assign illegal    = ctl.bad;

   always_comb begin
      case (ctl.wb)
         WB_LINK: rf_wd = pc_inc;
         WB_MEM:  rf_wd = dmem_rdata;
         default: rf_wd = alu_y;
      endcase
   end

   assign taken = (ctl.br_if_zero & (rd1 == '0)) | (ctl.br_if_nonzero & (rd1 != '0));

   always_comb begin
      if (ctl.is_jmp)  pc_nxt = rd1;
      else if (taken)  pc_nxt = br_tgt;
      else             pc_nxt = pc_inc;
   end

   always_ff @(posedge clk) begin
      if (rst) pc <= RESET_PC;
      else     pc <= pc_nxt;
   end

   assign imem_addr = pc;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic [XLEN-1:0] imem_addr,
   input logic [31:0]     imem_data,
   input logic            dmem_we,
   input logic            illegal,
   input logic            rf_we,
   input logic [XLEN-1:0] rf_wdata,
   input logic [XLEN-1:0] rd1
);
   logic [5:0] op;
   assign op = imem_data[31:26];

   p_reset_pc_r1: assert property (@(posedge clk) rst |=> imem_addr == '0);

   p_no_write_in_reset_r1: assert property (@(posedge clk) rst |-> (!dmem_we && !rf_we));

   p_illegal_quiet_r13: assert property (@(posedge clk) disable iff (rst)
      illegal |-> (!dmem_we && !rf_we));

   p_illegal_step_r13: assert property (@(posedge clk) disable iff (rst)
      illegal |=> imem_addr == $past(imem_addr) + XLEN'(1));

   p_store_only_r9: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> op == 6'h39);

   p_jmp_target_r12: assert property (@(posedge clk) disable iff (rst)
      (op == 6'h3B) |=> imem_addr == $past(rd1));

   p_link_value_r11: assert property (@(posedge clk) disable iff (rst)
      (op == 6'h3D || op == 6'h3E || op == 6'h3B) |-> (rf_we && rf_wdata == imem_addr + XLEN'(1)));

   p_zero_reg_r7: assert property (@(posedge clk) disable iff (rst)
      (imem_data[20:16] == 5'd31) |-> rd1 == '0);

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .imem_addr (imem_addr),
   .imem_data (imem_data),
   .dmem_we   (dmem_we),
   .illegal   (illegal),
   .rf_we     (rf_we),
   .rf_wdata  (rf_wd),
   .rd1       (rd1)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_data, dmem_addr, dmem_rdata, dmem_wdata;
   logic        dmem_we, illegal;

   always #2 clk = ~clk;

   sc_core u0 (
      .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
      .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_wdata(dmem_wdata),
      .dmem_we(dmem_we), .illegal(illegal)
   );

   logic [31:0] mem   [256];
   logic [31:0] m_mem [256];
   assign imem_data  = mem[imem_addr[7:0]];
   assign dmem_rdata = mem[dmem_addr[7:0]];
   always @(posedge clk) if (dmem_we) mem[dmem_addr[7:0]] <= dmem_wdata;

   int total = 0;
   int bad   = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h pc=%0d", req, act, exp, m_pc);
      end
   endtask

   // program assembly
   int p = 0;
   task automatic emit(input logic [31:0] w);
      mem[p] = w; m_mem[p] = w; p++;
   endtask
   function automatic logic [31:0] er(input logic [5:0] op, input int rc, input int ra, input int rb);
      return {op, 5'(rc), 5'(ra), 5'(rb), 11'd0};
   endfunction
   function automatic logic [31:0] ec(input logic [5:0] op, input int rc, input int ra, input int c);
      return {op, 5'(rc), 5'(ra), 16'(c)};
   endfunction

   // reference model state
   logic [31:0] m_r [32];
   string       m_tag [32];
   logic [31:0] m_pc = 0;
   string       pc_tag = "R2";
   bit          was_rst = 1'b1;

   function automatic bit alu_code(input logic [5:0] b);
      return b inside {6'h18, 6'h19, 6'h1C, 6'h1D, 6'h1E, 6'h20, 6'h21, 6'h22, 6'h24, 6'h25, 6'h26};
   endfunction

   function automatic logic [31:0] m_alu(input logic [5:0] b, input logic [31:0] x, input logic [31:0] y);
      case (b)
         6'h18: return x + y;
         6'h19: return x - y;
         6'h1C: return (x == y) ? 32'd1 : 32'd0;
         6'h1D: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
         6'h1E: return ($signed(x) <= $signed(y)) ? 32'd1 : 32'd0;
         6'h20: return x & y;
         6'h21: return x | y;
         6'h22: return x ^ y;
         6'h24: return x << y[4:0];
         6'h25: return x >> y[4:0];
         default: return $unsigned($signed(x) >>> y[4:0]);
      endcase
   endfunction

   function automatic string alu_tag(input logic [5:0] b, input bit cf);
      if (b inside {6'h1C, 6'h1D, 6'h1E}) return "R5";
      if (b inside {6'h24, 6'h25, 6'h26}) return "R6";
      return cf ? "R4" : "R3";
   endfunction

   always @(negedge clk) begin
      if (rst) begin
         m_pc    = 0;
         was_rst = 1'b1;
         pc_tag  = "R1";
      end else begin
         logic [31:0] w, a, b2, cs, res, addr, data, npc;
         logic [5:0]  op;
         int          rc, ra, rb;
         bit          wr, mw, ill;
         string       tag;
         if (was_rst) chk("R1 pc after reset", imem_addr, 32'd0);
         was_rst = 1'b0;
         chk(pc_tag, imem_addr, m_pc);
         w  = m_mem[m_pc[7:0]];
         op = w[31:26]; rc = int'(w[25:21]); ra = int'(w[20:16]); rb = int'(w[15:11]);
         cs = {{16{w[15]}}, w[15:0]};
         a  = (ra == 31) ? 32'd0 : m_r[ra];
         b2 = (rb == 31) ? 32'd0 : m_r[rb];
         wr = 0; mw = 0; ill = 0; res = 0; addr = 0; data = 0;
         npc = m_pc + 1; tag = "R2";
         if (alu_code(op)) begin
            wr = 1; res = m_alu(op, a, b2); tag = alu_tag(op, 0);
         end else if (op >= 6'h28 && op <= 6'h36 && alu_code(op - 6'h10)) begin
            wr = 1; res = m_alu(op - 6'h10, a, cs); tag = alu_tag(op - 6'h10, 1);
         end else begin
            case (op)
               6'h38: begin wr = 1; addr = a + cs; res = m_mem[addr[7:0]]; tag = "R8"; end
               6'h39: begin mw = 1; addr = a + cs; data = (rc == 31) ? 32'd0 : m_r[rc]; tag = "R9"; end
               6'h3F: begin wr = 1; addr = m_pc + 1 + cs; res = m_mem[addr[7:0]]; tag = "R10"; end
               6'h3B: begin wr = 1; res = m_pc + 1; npc = a; tag = "R12"; end
               6'h3D: begin wr = 1; res = m_pc + 1; if (a == 0) npc = m_pc + 1 + cs; tag = "R11"; end
               6'h3E: begin wr = 1; res = m_pc + 1; if (a != 0) npc = m_pc + 1 + cs; tag = "R11"; end
               default: begin ill = 1; tag = "R13"; end
            endcase
         end
         chk((ill ? "R13 illegal flag" : "R13 illegal flag low"), {31'd0, illegal}, {31'd0, ill});
         chk((ill ? "R13 no store" : "R9 store enable"), {31'd0, dmem_we}, {31'd0, mw});
         if (mw) begin
            chk("R9 store address", dmem_addr, addr);
            chk({"R9 store data from ", m_tag[rc]}, dmem_wdata, data);
            m_mem[addr[7:0]] = data;
         end
         if (wr && rc != 31) begin
            m_r[rc]   = res;
            m_tag[rc] = tag;
         end
         m_pc   = npc;
         pc_tag = tag;
      end
   end

   task automatic build_program();
      int j;
      for (int i = 0; i < 256; i++) begin mem[i] = 32'h0; m_mem[i] = 32'h0; end
      for (int i = 0; i < 32; i++) begin m_r[i] = 32'h0; m_tag[i] = "R7"; end
      emit(ec(6'h28, 1, 31, 5));          // r1 = 5
      emit(ec(6'h28, 2, 31, -3));         // r2 = -3
      emit(ec(6'h28, 20, 31, 7));         // r20 = 7
      emit(er(6'h18, 3, 1, 2));  emit(ec(6'h39, 3, 31, 200));
      emit(er(6'h19, 4, 1, 2));  emit(ec(6'h39, 4, 31, 201));
      emit(ec(6'h29, 4, 2, 7));  emit(ec(6'h39, 4, 31, 202));
      emit(ec(6'h30, 5, 2, 16'h00F0)); emit(ec(6'h39, 5, 31, 203));
      emit(ec(6'h31, 5, 1, 16'h8000)); emit(ec(6'h39, 5, 31, 204));
      emit(ec(6'h32, 5, 2, -1)); emit(ec(6'h39, 5, 31, 205));
      emit(er(6'h20, 6, 1, 2));  emit(ec(6'h39, 6, 31, 206));
      emit(er(6'h21, 7, 1, 2));  emit(ec(6'h39, 7, 31, 207));
      emit(er(6'h22, 8, 1, 2));  emit(ec(6'h39, 8, 31, 208));
      emit(er(6'h1C, 9, 1, 1));  emit(ec(6'h39, 9, 31, 209));
      emit(ec(6'h2C, 9, 1, 4));  emit(ec(6'h39, 9, 31, 210));
      emit(er(6'h1D, 9, 2, 1));  emit(ec(6'h39, 9, 31, 211));
      emit(er(6'h1D, 9, 1, 2));  emit(ec(6'h39, 9, 31, 212));
      emit(er(6'h1E, 9, 1, 1));  emit(ec(6'h39, 9, 31, 213));
      emit(ec(6'h2E, 9, 2, -3)); emit(ec(6'h39, 9, 31, 214));
      emit(ec(6'h2D, 9, 1, 5));  emit(ec(6'h39, 9, 31, 215));
      emit(ec(6'h34, 10, 1, 33)); emit(ec(6'h39, 10, 31, 216));
      emit(er(6'h25, 10, 2, 1)); emit(ec(6'h39, 10, 31, 217));
      emit(er(6'h26, 10, 2, 1)); emit(ec(6'h39, 10, 31, 218));
      emit(ec(6'h36, 10, 2, 36)); emit(ec(6'h39, 10, 31, 219));
      emit(ec(6'h35, 10, 2, 36)); emit(ec(6'h39, 10, 31, 220));
      emit(er(6'h24, 10, 2, 1)); emit(ec(6'h39, 10, 31, 221));
      // R7: write to r31 is dropped
      emit(ec(6'h28, 31, 1, 9)); emit(ec(6'h39, 31, 31, 230));
      emit(er(6'h18, 11, 31, 1)); emit(ec(6'h39, 11, 31, 222));
      // R8 loads
      emit(ec(6'h38, 12, 31, 200)); emit(ec(6'h39, 12, 31, 231));
      emit(ec(6'h38, 12, 1, 196));  emit(ec(6'h39, 12, 31, 232));
      emit(ec(6'h28, 13, 31, 240)); emit(ec(6'h39, 1, 13, -5));
      // R10: constant placed in the stream, skipped by a branch
      emit(ec(6'h3F, 14, 1, 1));
      emit(ec(6'h3D, 15, 31, 1));
      emit(32'hDEADBEEF);
      emit(ec(6'h39, 14, 31, 233)); emit(ec(6'h39, 15, 31, 234));
      // R11 conditional branches
      emit(ec(6'h3E, 16, 31, 5)); emit(ec(6'h39, 16, 31, 236));
      emit(ec(6'h3E, 16, 1, 1));  emit(ec(6'h28, 20, 31, 99));
      emit(ec(6'h39, 20, 31, 237)); emit(ec(6'h39, 16, 31, 238));
      emit(ec(6'h3D, 17, 1, 3));  emit(ec(6'h39, 17, 31, 239));
      // R12 jump
      j = p;
      emit(ec(6'h28, 18, 31, j + 3));
      emit(ec(6'h3B, 19, 18, 0));
      emit(ec(6'h28, 20, 31, 55));
      emit(ec(6'h39, 19, 31, 241)); emit(ec(6'h39, 20, 31, 242));
      // backward loop
      emit(ec(6'h28, 21, 31, 3));
      emit(ec(6'h29, 21, 21, 1));
      emit(ec(6'h3E, 31, 21, -2));
      emit(ec(6'h39, 21, 31, 243));
      // R13 illegal opcodes
      emit(ec(6'h00, 1, 1, 1));
      emit(ec(6'h3A, 1, 31, 244));
      emit(ec(6'h27, 1, 1, 1));
      emit(ec(6'h39, 1, 31, 245));
      // halt: self branch
      emit(ec(6'h3D, 31, 31, -1));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      build_program();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      repeat (170) @(posedge clk);
      #1 rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      repeat (30) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R9 final memory word 200", mem[200], m_mem[200]);
      chk("R7 final memory word 230", mem[230], 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule